// File: doc/BRIEF.md
# Digital Video Horizontal Window Generator

The block sits on an 8-bit multiplexed 4:2:2 video byte stream clocked by the pixel clock. It finds a line reference in one of two ways, picked by `ref_sel_i`. The first is the rising edge of an external horizontal sync input. The second is a start-of-active-video timing code embedded in the stream. At that reference it clears a 12-bit horizontal byte counter.

The counter is compared with a programmable begin and end position, which together form an active-video window. Each byte inside the window is tagged as Cb, Y or Cr, always starting with Cb. The byte stream itself passes through with a fixed latency of three clocks. The window flag and the component tag are delayed by the same amount, so all three stay aligned at the outputs.

A half-rate clock also leaves the block. It is forced high in the first active output cycle, so its high phase lines up with the chroma bytes of the window.

Top module: `vid_hwin`

## Requirements
- R1: `data_o` in cycle n equals `data_i` in cycle n-3.
- R2: With `ref_sel_i`=0, a cycle where `hs_i` is 1 and was 0 in the previous cycle is a reference. Holding `hs_i` high makes no further reference, and embedded codes are ignored.
- R3: With `ref_sel_i`=1, an embedded start code is a reference. The code is the bytes 0xFF, 0x00, 0x00 in three consecutive cycles, followed by a byte whose bit 4 is 0. Changes on `hs_i` are ignored.
- R4: A code whose last byte has bit 4 = 1 (end of active video) leaves the counter untouched.
- R5: The byte in the cycle after a reference has position 0, and each later byte has position +1. Before the first reference after reset, no byte is active. After the byte at position 4095, no byte is active until the next reference.
- R6: The byte at position p is active when begin < end and begin <= p <= end. `av_o` marks it in the same cycle that it appears on `data_o`.
- R7: If begin >= end, no byte on that line is active.
- R8: `comp_o` is 0 for inactive bytes. Active bytes are tagged 1 (Cb), 2 (Y), 3 (Cr), 2 (Y) in repeating order, and the byte at position begin is tagged Cb.
- R9: `clk2_o` is 1 in any output cycle where `av_o` rises. In every other cycle it inverts its previous value.
- R10: While `rst_ni` is low, `data_o`, `av_o`, `comp_o` and `clk2_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_sel_i | input | 1 | Line reference source: 0 sync input, 1 embedded code |
| hs_i | input | 1 | External horizontal sync, rising edge active |
| data_i | input | 8 | Multiplexed 4:2:2 byte stream |
| av_begin_i | input | 12 | Position of the first active byte |
| av_end_i | input | 12 | Position of the last active byte |
| data_o | output | 8 | Stream delayed by three clocks |
| av_o | output | 1 | Active-video flag aligned with `data_o` |
| comp_o | output | 2 | Component tag: 0 none, 1 Cb, 2 Y, 3 Cr |
| clk2_o | output | 1 | Half-rate clock phased to the window start |

## Verification
The assertions assume that `av_begin_i` and `av_end_i` are held steady while a line is in flight, because the window and the tag phase are computed against the live values. The stimulus only changes them between lines, after a flush of blanking bytes. A stream that is not preceded by a reference is expected to stay inactive. The blanking filler 0x80/0x10 never forms the 0xFF, 0x00, 0x00 preamble by accident, and active payload bytes are chosen to avoid 0xFF and 0x00. As a result, the only codes the detector sees are the ones a scenario places on purpose.

// File: rtl/vid_hwin_pkg.sv
package vid_hwin_pkg;
  typedef enum logic [1:0] {
    COMP_NONE = 2'd0,
    COMP_CB   = 2'd1,
    COMP_Y    = 2'd2,
    COMP_CR   = 2'd3
  } comp_e;
endpackage

// File: rtl/vid_hwin_ref.sv
module vid_hwin_ref #(
  parameter int DW = 8,
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_sel_i,
  input  logic          hs_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] pos_o,
  output logic          lock_o
);
  localparam int HBIT = DW - 4;
  localparam logic [CW-1:0] POS_MAX = '1;

  logic [DW-1:0] hist_q [3];
  logic          hs_q;
  logic [CW-1:0] pos_q;
  logic          lock_q;
  logic          sav_c, edge_c, ref_c;

  // hist_q[0] is the newest byte
  assign sav_c  = (hist_q[2] == '1) && (hist_q[1] == '0) && (hist_q[0] == '0) && !data_i[HBIT];
  assign edge_c = hs_i && !hs_q;
  assign ref_c  = ref_sel_i ? sav_c : edge_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) hist_q[i] <= '0;
      hs_q <= 1'b0;
    end else begin
      hist_q[0] <= data_i;
      for (int i = 1; i < 3; i++) hist_q[i] <= hist_q[i-1];
      hs_q <= hs_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      lock_q <= 1'b0;
    end else if (ref_c) begin
      pos_q  <= '0;
      lock_q <= 1'b1;
    end else if (pos_q != POS_MAX) begin
      pos_q  <= pos_q + CW'(1);
    end else begin
      lock_q <= 1'b0;
    end
  end

  assign pos_o  = pos_q;
  assign lock_o = lock_q;

  AST_REF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_c |=> (pos_q == '0) && lock_q); // R3
  AST_EDGE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_sel_i && hs_i) |=> !(edge_c && $past(hs_i))); // R2
  AST_POS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_c && pos_q != POS_MAX) |=> pos_q == $past(pos_q) + CW'(1)); // R5
  AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_c && pos_q == POS_MAX) |=> !lock_q); // R5
endmodule

// File: rtl/vid_hwin_win.sv
module vid_hwin_win
  import vid_hwin_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic [CW-1:0] pos_i,
  input  logic          lock_i,
  input  logic [CW-1:0] begin_i,
  input  logic [CW-1:0] end_i,
  output logic          av_o,
  output comp_e         comp_o
);
  logic [CW-1:0] offs;

  assign offs = pos_i - begin_i;
  assign av_o = lock_i && (begin_i < end_i) && (pos_i >= begin_i) && (pos_i <= end_i);

  always_comb begin
    comp_o = COMP_NONE;
    if (av_o) begin
      unique case (offs[1:0])
        2'd0:    comp_o = COMP_CB;
        2'd2:    comp_o = COMP_CR;
        default: comp_o = COMP_Y;
      endcase
    end
  end
endmodule

// File: rtl/vid_hwin_dly.sv
module vid_hwin_dly
  import vid_hwin_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DELAY = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          av_i,
  input  comp_e         comp_i,
  output logic [DW-1:0] data_o,
  output logic          av_o,
  output comp_e         comp_o,
  output logic          clk2_o
);
  localparam int LAST = DELAY - 1;

  logic [DW-1:0] data_q [DELAY];
  logic          av_q   [DELAY];
  comp_e         comp_q [DELAY];
  logic          clk2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DELAY; i++) begin
        data_q[i] <= '0;
        av_q[i]   <= 1'b0;
        comp_q[i] <= COMP_NONE;
      end
    end else begin
      data_q[0] <= data_i;
      av_q[0]   <= av_i;
      comp_q[0] <= comp_i;
      for (int i = 1; i < DELAY; i++) begin
        data_q[i] <= data_q[i-1];
        av_q[i]   <= av_q[i-1];
        comp_q[i] <= comp_q[i-1];
      end
    end
  end

  // force high when the window opens at the output next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          clk2_q <= 1'b0;
    else if (av_q[LAST-1] && !av_q[LAST]) clk2_q <= 1'b1;
    else                                  clk2_q <= !clk2_q;
  end

  assign data_o = data_q[LAST];
  assign av_o   = av_q[LAST];
  assign comp_o = comp_q[LAST];
  assign clk2_o = clk2_q;

  AST_FIRST_CB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(av_o) |-> comp_o == COMP_CB); // R8
  AST_TAG_AV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    av_o == (comp_o != COMP_NONE)); // R6
  AST_CLK2_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(av_o) |-> clk2_o); // R9
  AST_CLK2_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$rose(av_o)) |-> clk2_o != $past(clk2_o)); // R9
endmodule

// File: rtl/vid_hwin.sv
module vid_hwin
  import vid_hwin_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CW    = 12,
  parameter int DELAY = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_sel_i,
  input  logic          hs_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] av_begin_i,
  input  logic [CW-1:0] av_end_i,
  output logic [DW-1:0] data_o,
  output logic          av_o,
  output logic [1:0]    comp_o,
  output logic          clk2_o
);
  logic [CW-1:0] pos;
  logic          lock;
  logic          win_av;
  comp_e         win_comp;
  comp_e         out_comp;

  vid_hwin_ref #(.DW(DW), .CW(CW)) u_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_sel_i (ref_sel_i),
    .hs_i      (hs_i),
    .data_i    (data_i),
    .pos_o     (pos),
    .lock_o    (lock)
  );

  vid_hwin_win #(.CW(CW)) u_win (
    .pos_i   (pos),
    .lock_i  (lock),
    .begin_i (av_begin_i),
    .end_i   (av_end_i),
    .av_o    (win_av),
    .comp_o  (win_comp)
  );

  vid_hwin_dly #(.DW(DW), .DELAY(DELAY)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .av_i   (win_av),
    .comp_i (win_comp),
    .data_o (data_o),
    .av_o   (av_o),
    .comp_o (out_comp),
    .clk2_o (clk2_o)
  );

  assign comp_o = out_comp;

  AST_NO_WIN_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock |-> !win_av); // R5
endmodule

// File: tb/vid_hwin_test.sv
module vid_hwin_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_sel_i = 1'b0;
  logic        hs_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic [11:0] av_begin_i = 12'd0;
  logic [11:0] av_end_i = 12'd0;
  logic [7:0]  data_o;
  logic        av_o;
  logic [1:0]  comp_o;
  logic        clk2_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0]  h1 = 0, h2 = 0, h3 = 0;
  logic        hs_prev = 0;
  int          m_pos = 0;
  bit          m_lock = 0;
  logic [7:0]  qd [3] = '{default: 0};
  bit          qa [3] = '{default: 0};
  logic [1:0]  qc [3] = '{default: 0};
  bit          m_clk2 = 0;
  bit          prev_av = 0;
  bit          first = 1;
  int          act_cnt = 0;
  int          blank_ph = 0;

  always #4 clk = !clk;

  vid_hwin uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ref_sel_i  (ref_sel_i),
    .hs_i       (hs_i),
    .data_i     (data_i),
    .av_begin_i (av_begin_i),
    .av_end_i   (av_end_i),
    .data_o     (data_o),
    .av_o       (av_o),
    .comp_o     (comp_o),
    .clk2_o     (clk2_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] b, input logic h);
    bit ref_c, av_c;
    logic [1:0] c;
    int offs;
    @(negedge clk);
    if (first) m_clk2 = 0;
    else if (qa[0] && !prev_av) m_clk2 = 1;
    else m_clk2 = !m_clk2;
    first = 0;
    prev_av = qa[0];
    chk(data_o == qd[0], "R1 data", data_o, qd[0]);
    chk(av_o == qa[0], "R6 av", av_o, qa[0]);
    chk(comp_o == qc[0], "R8 comp", comp_o, qc[0]);
    chk(clk2_o == m_clk2, "R9 clk2", clk2_o, m_clk2);
    if (av_o) act_cnt++;
    data_i = b;
    hs_i = h;
    if (ref_sel_i) ref_c = (h3 == 8'hFF) && (h2 == 8'h00) && (h1 == 8'h00) && !b[4];
    else           ref_c = h && !hs_prev;
    av_c = m_lock && (av_begin_i < av_end_i) && (m_pos >= int'(av_begin_i)) && (m_pos <= int'(av_end_i));
    offs = m_pos - int'(av_begin_i);
    c = !av_c ? 2'd0 : (offs % 4 == 0) ? 2'd1 : (offs % 4 == 2) ? 2'd3 : 2'd2;
    qd[0] = qd[1]; qd[1] = qd[2]; qd[2] = b;
    qa[0] = qa[1]; qa[1] = qa[2]; qa[2] = av_c;
    qc[0] = qc[1]; qc[1] = qc[2]; qc[2] = c;
    h3 = h2; h2 = h1; h1 = b; hs_prev = h;
    if (ref_c) begin m_pos = 0; m_lock = 1; end
    else if (m_pos != 4095) m_pos++;
    else m_lock = 0;
  endtask

  task automatic blank(input int n, input logic h);
    for (int i = 0; i < n; i++) begin
      step(blank_ph[0] ? 8'h10 : 8'h80, h);
      blank_ph++;
    end
  endtask

  task automatic payload(input int n, input logic h);
    for (int i = 0; i < n; i++) step(8'h20 + 8'(i), h);
  endtask

  task automatic code(input logic [7:0] xy, input logic h);
    step(8'hFF, h); step(8'h00, !h); step(8'h00, h); step(xy, !h);
  endtask

  task automatic test_reset;
    repeat (3) @(posedge clk);
    #1;
    chk(data_o == 8'h00, "R10 data", data_o, 0);
    chk(av_o == 1'b0, "R10 av", av_o, 0);
    chk(comp_o == 2'd0, "R10 comp", comp_o, 0);
    chk(clk2_o == 1'b0, "R10 clk2", clk2_o, 0);
    @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  // R2, R5, R6: sync edge reference, no window before it
  task automatic test_ext_line;
    ref_sel_i = 0; av_begin_i = 12'd4; av_end_i = 12'd11;
    act_cnt = 0;
    blank(6, 1'b0);
    blank(1, 1'b1);
    blank(4, 1'b1);
    payload(16, 1'b0);
    blank(6, 1'b0);
    chk(act_cnt == 8, "R6 ext window size", act_cnt, 8);
  endtask

  // R2: embedded code ignored in sync mode
  task automatic test_ext_ignore;
    ref_sel_i = 0; av_begin_i = 12'd1; av_end_i = 12'd6;
    act_cnt = 0;
    blank(1, 1'b1);
    blank(3, 1'b1);
    step(8'hFF, 1'b1); step(8'h00, 1'b1); step(8'h00, 1'b1); step(8'h80, 1'b1);
    payload(12, 1'b1);
    blank(6, 1'b0);
    chk(act_cnt == 6, "R2 code ignored", act_cnt, 6);
  endtask

  // R3: embedded start code, hs toggling ignored
  task automatic test_emb_line;
    ref_sel_i = 1; av_begin_i = 12'd2; av_end_i = 12'd9;
    act_cnt = 0;
    blank(4, 1'b0);
    code(8'h80, 1'b1);
    payload(12, 1'b1);
    code(8'h9D, 1'b0);
    blank(6, 1'b1);
    chk(act_cnt == 8, "R3 emb window size", act_cnt, 8);
  endtask

  // R4: end code does not restart the count
  task automatic test_emb_eav;
    ref_sel_i = 1; av_begin_i = 12'd1; av_end_i = 12'd9;
    act_cnt = 0;
    code(8'hAB, 1'b0);
    payload(3, 1'b1);
    code(8'hB6, 1'b1);
    payload(10, 1'b0);
    blank(6, 1'b0);
    chk(act_cnt == 9, "R4 end code ignored", act_cnt, 9);
  endtask

  // R7: empty windows
  task automatic test_empty;
    ref_sel_i = 1; av_begin_i = 12'd5; av_end_i = 12'd5;
    act_cnt = 0;
    code(8'h80, 1'b0);
    payload(12, 1'b0);
    av_begin_i = 12'd9; av_end_i = 12'd3;
    code(8'h80, 1'b0);
    payload(12, 1'b0);
    blank(6, 1'b0);
    chk(act_cnt == 0, "R7 empty window", act_cnt, 0);
  endtask

  // R5: counter end of range drops the window
  task automatic test_saturate;
    ref_sel_i = 1; av_begin_i = 12'd4094; av_end_i = 12'd4095;
    act_cnt = 0;
    code(8'h80, 1'b0);
    blank(4110, 1'b0);
    chk(act_cnt == 2, "R5 end of count", act_cnt, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_ext_line();
    test_ext_ignore();
    test_emb_line();
    test_emb_eav();
    test_empty();
    test_saturate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule